// File: doc/BRIEF.md
# Calendar Real-Time Clock with Field Alarm

This block is a memory-mapped calendar clock. Eight counters hold the time: seconds, minutes, hours, day of week, day of month, day of year, month and year. They move forward by one second on each cycle where the one-second strobe `sec_tick` is high and the run bit is set. Rollover follows the calendar, with month lengths and a leap rule of one in four years. Software sees a flat 32-bit register space. Each time field can be read and written at its own word address. Three packed words give the whole date in three reads.

Each counter has an alarm compare register. An eight-bit alarm mask takes individual fields out of the compare. A status register has two flags, one for a chosen counter advancing and one for an alarm match. Each flag is cleared by writing a one to it. The single interrupt line is the OR of the two flags. The bus is a plain synchronous write strobe with a combinational read data path. A parameter can add a registered read path instead.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, control (0x08) reads 0, status (0x00) reads 0, increment select (0x0C) reads 0 and alarm mask (0x10) reads 0xFF. `irq` is low. The time is 00:00:00, day of week 0, day of month 1, day of year 1, month 1, year 0.
- R2: Counters advance only on a cycle where `sec_tick` is high and control bit 0 is set. Otherwise they hold. Control bit 4 can be written and read back but does not affect counting.
- R3: Seconds and minutes go from 59 to 0 and carry into the next field. Hours go from 23 to 0 and start a new day.
- R4: On a new day, day of week goes from 6 to 0, day of year adds 1, and day of month goes back to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days, and all other months except February have 31.
- R5: February has 29 days when the year is a multiple of 4 and 28 days otherwise.
- R6: After month 12 ends, the month goes to 1, the year adds 1 and day of year goes back to 1.
- R7: A write to a time field at 0x20 + 4*i loads that field. The field index i runs 0 to 7 in this order: seconds, minutes, hours, day of month, day of week, day of year, month, year. The alarm fields are at 0x60 + 4*i. A cycle with a time-field write does no counting, even if `sec_tick` is high.
- R8: Packed word 0x14 holds seconds in [5:0], minutes in [13:8], hours in [20:16] and day of week in [26:24]. Word 0x18 holds day of month in [4:0], month in [11:8] and year in [27:16]. Word 0x1C holds day of year in [11:0]. All other bits read 0.
- R9: Mask bit i removes field i from the alarm compare. Status bit 1 sets one cycle after the counters or alarm registers first reach a state where every unmasked field is equal. It does not set again while that match lasts, and it never sets when the mask is 0xFF.
- R10: When field i advances by counting and increment-select bit i is set, status bit 0 sets in the same clock edge as the counter update.
- R11: Writing 1 to a status bit clears it, and writing 0 leaves it as it is. If a set event and a clearing write fall in the same cycle, the flag stays set.
- R12: `irq` is high exactly when either status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe per elapsed second |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` |
| irq | output | 1 | Interrupt, OR of the status flags |

## Verification
Two functions can hit status bit 0 in the same cycle: a counter advance selected by the increment-select register, and a software write of one to that bit. The bench forces this by driving `sec_tick` and a status write on the same clock, with seconds selected, and expects the flag to read as still set. A second write made without a tick must then clear it. A time-field write together with a tick is a second case of this kind. The loaded value must win, and no carry may appear in any field.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int NFLD = 8;
   localparam int FW   = 12;

   localparam int I_SEC  = 0;
   localparam int I_MIN  = 1;
   localparam int I_HOUR = 2;
   localparam int I_DOM  = 3;
   localparam int I_DOW  = 4;
   localparam int I_DOY  = 5;
   localparam int I_MON  = 6;
   localparam int I_YEAR = 7;

   localparam logic [4:0] OFS_STAT = 5'h00;
   localparam logic [4:0] OFS_CTRL = 5'h08;
   localparam logic [4:0] OFS_ISEL = 5'h0C;
   localparam logic [4:0] OFS_AMSK = 5'h10;
   localparam logic [4:0] OFS_PK0  = 5'h14;
   localparam logic [4:0] OFS_PK1  = 5'h18;
   localparam logic [4:0] OFS_PK2  = 5'h1C;

   // upper address bits selecting each 32-byte page
   localparam int PAGE_CTL  = 0;
   localparam int PAGE_TIME = 1;
   localparam int PAGE_ALM  = 3;

   function automatic int fld_bits(input int idx);
      case (idx)
         I_SEC, I_MIN:   return 6;
         I_HOUR, I_DOM:  return 5;
         I_DOW:          return 3;
         I_MON:          return 4;
         default:        return FW;
      endcase
   endfunction

   function automatic logic [FW-1:0] fld_mask(input int idx);
      logic [FW-1:0] one;
      one = 1;
      return (one << fld_bits(idx)) - one;
   endfunction

   function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
      case (mon)
         4'd2:                   return leap ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
         default:                return 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_cal_count.sv
module rtc_cal_count
   import rtc_cal_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      step,
   input  logic [NFLD-1:0]           ld_sel,
   input  logic [FW-1:0]             ld_val,
   output logic [NFLD-1:0][FW-1:0]   cur,
   output logic [NFLD-1:0]           adv
);

   localparam logic [FW-1:0] ONE_FW = 1;

   logic [5:0]    sec_q, min_q;
   logic [4:0]    hour_q, dom_q;
   logic [2:0]    dow_q;
   logic [FW-1:0] doy_q, year_q;
   logic [3:0]    mon_q;

   logic       go, c_min, c_hour, c_day, c_mon, c_year;
   logic [4:0] mlen;

   always_comb begin
      go     = step & ~(|ld_sel);
      mlen   = month_days(mon_q, year_q[1:0] == 2'b00);
      c_min  = go & (sec_q >= 6'd59);
      c_hour = c_min & (min_q >= 6'd59);
      c_day  = c_hour & (hour_q >= 5'd23);
      c_mon  = c_day & (dom_q >= mlen);
      c_year = c_mon & (mon_q >= 4'd12);
   end

   assign adv = {c_year, c_mon, c_day, c_day, c_day, c_hour, c_min, go};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q  <= '0;
         min_q  <= '0;
         hour_q <= '0;
         dom_q  <= 5'd1;
         dow_q  <= '0;
         doy_q  <= ONE_FW;
         mon_q  <= 4'd1;
         year_q <= '0;
      end else if (|ld_sel) begin
         if (ld_sel[I_SEC])  sec_q  <= ld_val[5:0];
         if (ld_sel[I_MIN])  min_q  <= ld_val[5:0];
         if (ld_sel[I_HOUR]) hour_q <= ld_val[4:0];
         if (ld_sel[I_DOM])  dom_q  <= ld_val[4:0];
         if (ld_sel[I_DOW])  dow_q  <= ld_val[2:0];
         if (ld_sel[I_DOY])  doy_q  <= ld_val;
         if (ld_sel[I_MON])  mon_q  <= ld_val[3:0];
         if (ld_sel[I_YEAR]) year_q <= ld_val;
      end else if (go) begin
         sec_q <= c_min ? 6'd0 : sec_q + 6'd1;
         if (c_min)  min_q  <= c_hour ? 6'd0 : min_q + 6'd1;
         if (c_hour) hour_q <= c_day ? 5'd0 : hour_q + 5'd1;
         if (c_day) begin
            dom_q <= c_mon ? 5'd1 : dom_q + 5'd1;
            dow_q <= (dow_q >= 3'd6) ? 3'd0 : dow_q + 3'd1;
            doy_q <= c_year ? ONE_FW : doy_q + ONE_FW;
         end
         if (c_mon)  mon_q  <= c_year ? 4'd1 : mon_q + 4'd1;
         if (c_year) year_q <= year_q + ONE_FW;
      end
   end

   always_comb begin
      cur         = '0;
      cur[I_SEC]  = {{(FW-6){1'b0}}, sec_q};
      cur[I_MIN]  = {{(FW-6){1'b0}}, min_q};
      cur[I_HOUR] = {{(FW-5){1'b0}}, hour_q};
      cur[I_DOM]  = {{(FW-5){1'b0}}, dom_q};
      cur[I_DOW]  = {{(FW-3){1'b0}}, dow_q};
      cur[I_DOY]  = doy_q;
      cur[I_MON]  = {{(FW-4){1'b0}}, mon_q};
      cur[I_YEAR] = year_q;
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && ld_sel == '0) |=> $stable(cur));                         // R2
   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (go && sec_q == 6'd59) |=> (sec_q == 6'd0));                       // R3
   AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (c_day && dow_q == 3'd6) |=> (dow_q == 3'd0));                     // R4
   AST_YEAR_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      c_year |=> (mon_q == 4'd1 && doy_q == ONE_FW && dom_q == 5'd1));   // R6
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (step && ld_sel[I_SEC]) |=> (sec_q == $past(ld_val[5:0])));        // R7

endmodule

// File: rtl/rtc_cal_alarm.sv
module rtc_cal_alarm
   import rtc_cal_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NFLD-1:0]           ld_sel,
   input  logic [FW-1:0]             ld_val,
   input  logic [NFLD-1:0]           mask,
   input  logic [NFLD-1:0][FW-1:0]   cur,
   output logic [NFLD-1:0][FW-1:0]   alm,
   output logic                      hit
);

   logic [NFLD-1:0] eq;
   logic            match, match_q;

   for (genvar i = 0; i < NFLD; i++) begin : g_fld
      localparam logic [FW-1:0] WMASK = fld_mask(i);
      always_ff @(posedge clk) begin
         if (!rst_n)         alm[i] <= '0;
         else if (ld_sel[i]) alm[i] <= ld_val & WMASK;
      end
      assign eq[i] = mask[i] | (alm[i] == cur[i]);
   end

   assign match = (&eq) & ~(&mask);

   always_ff @(posedge clk) begin
      if (!rst_n) match_q <= 1'b0;
      else        match_q <= match;
   end

   assign hit = match & ~match_q;

   AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '1) |-> !hit);                                            // R9
   AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit);                                                     // R9

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_cal_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter bit READ_REG = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   localparam int PG_W = ADDR_W - 5;

   if (ADDR_W < 7) begin : g_bad_addr
      $error("rtc_calendar: ADDR_W must reach offset 0x7C");
   end
   if (DATA_W < 28) begin : g_bad_data
      $error("rtc_calendar: DATA_W must hold the packed year field");
   end

   logic [PG_W-1:0]          page;
   logic [2:0]               fidx;
   logic                     word_ok, ctl_wr;
   logic [NFLD-1:0]          t_sel, a_sel;
   logic [NFLD-1:0][FW-1:0]  cur, alm;
   logic [NFLD-1:0]          adv;
   logic                     alm_hit, inc_set;
   logic                     run_q, cal_q;
   logic [NFLD-1:0]          isel_q, amsk_q;
   logic [1:0]               sts_q;
   logic                     sts_wr;
   logic [DATA_W-1:0]        rd_c;

   assign page    = bus_addr[ADDR_W-1:5];
   assign fidx    = bus_addr[4:2];
   assign word_ok = (bus_addr[1:0] == 2'b00);
   assign ctl_wr  = bus_we & word_ok & (page == PG_W'(PAGE_CTL));
   assign sts_wr  = ctl_wr & (bus_addr[4:0] == OFS_STAT);

   always_comb begin
      t_sel = '0;
      a_sel = '0;
      if (bus_we && word_ok && page == PG_W'(PAGE_TIME)) t_sel[fidx] = 1'b1;
      if (bus_we && word_ok && page == PG_W'(PAGE_ALM))  a_sel[fidx] = 1'b1;
   end

   rtc_cal_count u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (sec_tick & run_q),
      .ld_sel (t_sel),
      .ld_val (bus_wdata[FW-1:0]),
      .cur    (cur),
      .adv    (adv)
   );

   rtc_cal_alarm u_alarm (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_sel (a_sel),
      .ld_val (bus_wdata[FW-1:0]),
      .mask   (amsk_q),
      .cur    (cur),
      .alm    (alm),
      .hit    (alm_hit)
   );

   assign inc_set = |(adv & isel_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         cal_q  <= 1'b0;
         isel_q <= '0;
         amsk_q <= '1;
         sts_q  <= '0;
      end else begin
         if (ctl_wr && bus_addr[4:0] == OFS_CTRL) begin
            run_q <= bus_wdata[0];
            cal_q <= bus_wdata[4];
         end
         if (ctl_wr && bus_addr[4:0] == OFS_ISEL) isel_q <= bus_wdata[NFLD-1:0];
         if (ctl_wr && bus_addr[4:0] == OFS_AMSK) amsk_q <= bus_wdata[NFLD-1:0];
         sts_q[0] <= inc_set | (sts_q[0] & ~(sts_wr & bus_wdata[0]));
         sts_q[1] <= alm_hit | (sts_q[1] & ~(sts_wr & bus_wdata[1]));
      end
   end

   assign irq = |sts_q;

   always_comb begin
      rd_c = '0;
      if (word_ok) begin
         if (page == PG_W'(PAGE_TIME)) begin
            rd_c[FW-1:0] = cur[fidx];
         end else if (page == PG_W'(PAGE_ALM)) begin
            rd_c[FW-1:0] = alm[fidx];
         end else if (page == PG_W'(PAGE_CTL)) begin
            case (bus_addr[4:0])
               OFS_STAT: rd_c[1:0] = sts_q;
               OFS_CTRL: begin
                  rd_c[0] = run_q;
                  rd_c[4] = cal_q;
               end
               OFS_ISEL: rd_c[NFLD-1:0] = isel_q;
               OFS_AMSK: rd_c[NFLD-1:0] = amsk_q;
               OFS_PK0: begin
                  rd_c[5:0]   = cur[I_SEC][5:0];
                  rd_c[13:8]  = cur[I_MIN][5:0];
                  rd_c[20:16] = cur[I_HOUR][4:0];
                  rd_c[26:24] = cur[I_DOW][2:0];
               end
               OFS_PK1: begin
                  rd_c[4:0]   = cur[I_DOM][4:0];
                  rd_c[11:8]  = cur[I_MON][3:0];
                  rd_c[27:16] = cur[I_YEAR];
               end
               OFS_PK2: rd_c[FW-1:0] = cur[I_DOY];
               default: rd_c = '0;
            endcase
         end
      end
   end

   if (READ_REG) begin : g_rd_flop
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_c;
      end
      assign bus_rdata = rd_q;
   end else begin : g_rd_comb
      assign bus_rdata = rd_c;
   end

   AST_ALARM_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q[1]) |-> ($past(amsk_q) != '1));                        // R9
   AST_INC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      inc_set |=> sts_q[0]);                                             // R10
   AST_W1C_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && bus_wdata[1] && !alm_hit) |=> !sts_q[1]);               // R11
   AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[0] && !(sts_wr && bus_wdata[0])) |=> sts_q[0]);             // R11
   AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> ($past(sts_wr) && sts_q == 2'b00));                 // R12

endmodule

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;

   localparam logic [7:0] A_STAT = 8'h00, A_CTRL = 8'h08, A_ISEL = 8'h0C, A_AMSK = 8'h10;
   localparam logic [7:0] A_PK0 = 8'h14, A_PK1 = 8'h18, A_PK2 = 8'h1C;
   localparam logic [7:0] A_SEC = 8'h20, A_MIN = 8'h24, A_HOUR = 8'h28, A_DOM = 8'h2C;
   localparam logic [7:0] A_DOW = 8'h30, A_DOY = 8'h34, A_MON = 8'h38, A_YEAR = 8'h3C;
   localparam logic [7:0] A_ALM = 8'h40;

   always #5 clk = ~clk;

   rtc_calendar u_rtc_calendar (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d; sec_tick = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; sec_tick = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic load(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                       input logic [7:0] dom, input logic [7:0] mon, input logic [11:0] yr);
      wr(A_SEC, {24'd0, s});
      wr(A_MIN, {24'd0, m});
      wr(A_HOUR, {24'd0, h});
      wr(A_DOM, {24'd0, dom});
      wr(A_MON, {24'd0, mon});
      wr(A_YEAR, {20'd0, yr});
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_CTRL, v); chk("R1", "ctrl", v, 32'h0);
      rd(A_STAT, v); chk("R1", "status", v, 32'h0);
      rd(A_ISEL, v); chk("R1", "isel", v, 32'h0);
      rd(A_AMSK, v); chk("R1", "mask", v, 32'hFF);
      rd(A_PK0, v);  chk("R1", "packed0", v, 32'h0);
      rd(A_PK1, v);  chk("R1", "packed1", v, 32'h0000_0101);
      rd(A_PK2, v);  chk("R1", "packed2", v, 32'h1);
      chk("R1", "irq", {31'd0, irq}, 32'h0);
   endtask

   task automatic t_run_gate();
      logic [31:0] v;
      tick();
      rd(A_SEC, v); chk("R2", "stopped sec", v, 32'h0);
      wr(A_CTRL, 32'h10);
      rd(A_CTRL, v); chk("R2", "cal bit readback", v, 32'h10);
      tick();
      rd(A_SEC, v); chk("R2", "cal bit only sec", v, 32'h0);
      wr(A_CTRL, 32'h11);
      tick();
      rd(A_SEC, v); chk("R2", "running sec", v, 32'h1);
      repeat (3) @(negedge clk);
      rd(A_SEC, v); chk("R2", "no tick hold", v, 32'h1);
   endtask

   task automatic t_day_roll();
      logic [31:0] v;
      load(8'd59, 8'd59, 8'd23, 8'd10, 8'd5, 12'd100);
      wr(A_DOW, 32'd6);
      wr(A_DOY, 32'd100);
      tick();
      rd(A_PK0, v); chk("R3", "midnight packed0", v, 32'h0);
      rd(A_DOM, v); chk("R4", "dom step", v, 32'd11);
      rd(A_DOY, v); chk("R4", "doy step", v, 32'd101);
      rd(A_MON, v); chk("R4", "month held", v, 32'd5);
      wr(A_SEC, 32'd59);
      wr(A_MIN, 32'd10);
      tick();
      rd(A_PK0, v); chk("R3", "minute carry", v, 32'h0000_0B00);
   endtask

   task automatic t_month_len();
      logic [31:0] v;
      load(8'd59, 8'd59, 8'd23, 8'd30, 8'd4, 12'd100);
      tick();
      rd(A_PK1, v); chk("R4", "30-day month end", v, 32'h0064_0501);
      load(8'd59, 8'd59, 8'd23, 8'd30, 8'd5, 12'd100);
      tick();
      rd(A_PK1, v); chk("R4", "31-day month day 31", v, 32'h0064_051F);
   endtask

   task automatic t_leap();
      logic [31:0] v;
      load(8'd59, 8'd59, 8'd23, 8'd28, 8'd2, 12'd2024);
      tick();
      rd(A_PK1, v); chk("R5", "leap feb 29", v, 32'h07E8_021D);
      load(8'd59, 8'd59, 8'd23, 8'd29, 8'd2, 12'd2024);
      tick();
      rd(A_PK1, v); chk("R5", "leap to march", v, 32'h07E8_0301);
      load(8'd59, 8'd59, 8'd23, 8'd28, 8'd2, 12'd2023);
      tick();
      rd(A_PK1, v); chk("R5", "common to march", v, 32'h07E7_0301);
   endtask

   task automatic t_year();
      logic [31:0] v;
      load(8'd59, 8'd59, 8'd23, 8'd31, 8'd12, 12'd2023);
      wr(A_DOY, 32'd365);
      tick();
      rd(A_PK1, v); chk("R6", "new year packed1", v, 32'h07E8_0101);
      rd(A_PK2, v); chk("R6", "new year doy", v, 32'h1);
   endtask

   task automatic t_write_wins();
      logic [31:0] v;
      wr(A_MIN, 32'd20);
      wr(A_SEC, 32'd59);
      wr_tick(A_SEC, 32'd10);
      rd(A_SEC, v); chk("R7", "write beats tick sec", v, 32'd10);
      rd(A_MIN, v); chk("R7", "no carry on write", v, 32'd20);
   endtask

   task automatic t_packed();
      logic [31:0] v;
      load(8'd42, 8'd21, 8'd19, 8'd23, 8'd9, 12'hABC);
      wr(A_DOW, 32'd5);
      wr(A_DOY, 32'h16D);
      rd(A_PK0, v);  chk("R8", "packed0 layout", v, 32'h0513_152A);
      rd(A_PK1, v);  chk("R8", "packed1 layout", v, 32'h0ABC_0917);
      rd(A_PK2, v);  chk("R8", "packed2 layout", v, 32'h0000_016D);
      rd(A_YEAR, v); chk("R7", "year field", v, 32'h0000_0ABC);
   endtask

   task automatic t_alarm();
      logic [31:0] v;
      wr(A_STAT, 32'h3);
      wr(A_SEC, 32'd5);
      wr(A_MIN, 32'd7);
      wr(A_ALM + A_SEC, 32'd6);
      wr(A_ALM + A_MIN, 32'd33);
      rd(A_ALM + A_MIN, v); chk("R7", "alarm field readback", v, 32'd33);
      wr(A_AMSK, 32'hFE);
      tick();
      rd(A_STAT, v); chk("R9", "alarm not yet", v, 32'h0);
      @(negedge clk);
      rd(A_STAT, v); chk("R9", "alarm flag", v, 32'h2);
      chk("R12", "irq on alarm", {31'd0, irq}, 32'h1);
      wr(A_STAT, 32'h2);
      rd(A_STAT, v); chk("R11", "alarm cleared", v, 32'h0);
      @(negedge clk);
      rd(A_STAT, v); chk("R9", "no refire in match", v, 32'h0);
      chk("R12", "irq low", {31'd0, irq}, 32'h0);
      wr(A_AMSK, 32'hFF);
      wr(A_SEC, 32'd5);
      tick();
      repeat (2) @(negedge clk);
      rd(A_STAT, v); chk("R9", "full mask silent", v, 32'h0);
   endtask

   task automatic t_incsel();
      logic [31:0] v;
      wr(A_ISEL, 32'h02);
      wr(A_SEC, 32'd10);
      tick();
      rd(A_STAT, v); chk("R10", "sec step minute unselected", v, 32'h0);
      wr(A_SEC, 32'd59);
      tick();
      rd(A_STAT, v); chk("R10", "minute advance flag", v, 32'h1);
      chk("R12", "irq on increment", {31'd0, irq}, 32'h1);
   endtask

   task automatic t_w1c();
      logic [31:0] v;
      wr(A_STAT, 32'h2);
      rd(A_STAT, v); chk("R11", "write other bit keeps", v, 32'h1);
      wr(A_STAT, 32'h0);
      rd(A_STAT, v); chk("R11", "write zero keeps", v, 32'h1);
      wr(A_STAT, 32'h1);
      rd(A_STAT, v); chk("R11", "write one clears", v, 32'h0);
      chk("R12", "irq after clear", {31'd0, irq}, 32'h0);
   endtask

   task automatic t_set_wins();
      logic [31:0] v;
      wr(A_ISEL, 32'h01);
      tick();
      rd(A_STAT, v); chk("R10", "seconds flag", v, 32'h1);
      wr_tick(A_STAT, 32'h1);
      rd(A_STAT, v); chk("R11", "set beats clear", v, 32'h1);
      wr(A_STAT, 32'h1);
      rd(A_STAT, v); chk("R11", "clear alone", v, 32'h0);
      wr(A_ISEL, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_run_gate();
      t_day_roll();
      t_month_len();
      t_leap();
      t_year();
      t_write_wins();
      t_packed();
      t_alarm();
      t_incsel();
      t_w1c();
      t_set_wins();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule